// File: doc/BRIEF.md
# Planar Pixel Serializer

This block turns bytes fetched from four bit planes into a stream of 4-bit colour indices, one pixel per dot. Every pixel takes one bit from each plane, in the same bit position. Plane 0 supplies the blue bit, plane 1 green, plane 2 red and plane 3 intensity. The fetch side hands over one 16-bit lane per plane through a valid/ready handshake. A pixel strobe marks each new colour index for the palette stage that follows.

A 4-bit mode input configures the block:
- Bit 0 selects an 8-dot or a 9-dot character cell. In the 9-dot cell the extra dot is blank.
- Bit 2 selects a reload every character, using the low byte of each lane, or a reload every second character. In the second case the lane is a chained 16-bit word and its high byte goes out first.
- Bit 3 halves the dot rate, so each pixel lasts two clocks.

A decoded two-plane monochrome class (planes 2 and 0) is also provided for monochrome graphics displays.

Back-pressure rules: `in_ready` is high when the block holds no data, and also on the final clock of the data it holds. A transfer happens on any clock edge where `in_valid` and `in_ready` are both high. Once `in_valid` is raised, the source keeps it high, with `in_planes` unchanged, until the transfer. If no new data arrives by the end of the held data, the block stalls: `pix_valid` stays low and `pix_index` is 0 until the next transfer. The pixel side has no back-pressure.

Top module: `planar_serializer`

## Requirements
- R1: Bit p of `pix_index` is the shown bit of plane p. Plane p occupies `in_planes[16*p+15 : 16*p]`. Bits 3, 2, 1 and 0 are intensity, red, green and blue.
- R2: Inside each byte, bit 7 is shown first and bit 0 is shown last.
- R3: `clk_mode[0]`=1 gives an 8-dot character. `clk_mode[0]`=0 gives a 9-dot character whose ninth dot has `pix_index`=0 and carries a `pix_valid` strobe.
- R4: `clk_mode[3]`=0 gives a new pixel every clock. `clk_mode[3]`=1 holds each pixel for two clocks: `pix_valid` is high on the first clock only, and `pix_index` is unchanged on the second.
- R5: `clk_mode[2]`=0 takes one transfer per character and shows bits [7:0] of each lane. `clk_mode[2]`=1 takes one transfer per two characters and shows bits [15:8] of each lane before bits [7:0].
- R6: `in_ready` is high exactly when no data is held or the current clock is the last one of the held data. A transfer puts its first pixel on the outputs in the next clock, so back-to-back transfers leave no gap.
- R7: While no data is held, `pix_valid` is 0 and `pix_index` is 0.
- R8: `pix_mono` equals {`pix_index[2]`, `pix_index[0]`}. Its codes are 0 for black, 1 for video, 2 for blinking and 3 for intensified.
- R9: Synchronous reset `rst` discards any held data. On the first clock after reset, `pix_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_mode | input | 4 | Bit 0 selects the 8-dot cell, bit 2 selects chained 16-bit loads, bit 3 selects the half dot rate |
| in_valid | input | 1 | Plane data offered |
| in_ready | output | 1 | Load request: new plane data is accepted this clock |
| in_planes | input | 64 | Four 16-bit plane lanes, plane 0 in the low lane |
| pix_valid | output | 1 | Strobe for a new pixel |
| pix_index | output | 4 | Colour index {I,R,G,B} |
| pix_mono | output | 2 | Monochrome class from planes 2 and 0 |

## Verification
The assertions assume that the source obeys the handshake: `in_valid` and `in_planes` stay unchanged until a transfer takes place. They also assume that `clk_mode` changes only while the block is idle, because a change in mid-character would make the length of the character undefined. The stimulus runs all eight mode combinations. Before each change of mode it drains the block with `in_valid` low, and it holds every offered word until the model predicts acceptance. Some stretches feed words back to back and others leave idle gaps, so both the continuous stream and the starved state are covered.

// File: rtl/planar_serializer_pkg.sv
package planar_serializer_pkg;
  typedef enum logic [1:0] {
    MONO_BLACK  = 2'd0,
    MONO_VIDEO  = 2'd1,
    MONO_BLINK  = 2'd2,
    MONO_BRIGHT = 2'd3
  } mono_kind_t;

  localparam int MODE_BIT_DOT8  = 0;
  localparam int MODE_BIT_CHAIN = 2;
  localparam int MODE_BIT_HALF  = 3;
  localparam int MODE_W         = 4;
endpackage

// File: rtl/plane_shifter.sv
module plane_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] load_word,
  output logic              top_bit
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (load) begin
      sr <= load_word;
    end else if (shift) begin
      sr <= {sr[WORD_W-2:0], 1'b0};
    end
  end

  assign top_bit = sr[WORD_W-1];
endmodule

// File: rtl/dot_timer.sv
module dot_timer #(
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic dot8,
  input  logic chain,
  input  logic half,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic shift,
  output logic pad,
  output logic holding,
  output logic pix_valid
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST8 = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST9 = CNT_W'(BYTE_W);

  logic             full;
  logic             phase;
  logic             char_hi;
  logic [CNT_W-1:0] dot_cnt;
  logic             tick;
  logic             last_dot;
  logic             last_tick;

  assign tick      = full && (!half || phase);
  assign last_dot  = dot8 ? (dot_cnt == LAST8) : (dot_cnt == LAST9);
  assign last_tick = tick && last_dot && (!chain || char_hi);
  assign in_ready  = !full || last_tick;
  assign accept    = in_valid && in_ready;
  assign pad       = (dot_cnt == LAST9);
  assign shift     = tick && !pad && !accept;
  assign holding   = full;
  assign pix_valid = full && !phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      full    <= 1'b0;
      phase   <= 1'b0;
      char_hi <= 1'b0;
      dot_cnt <= '0;
    end else if (accept) begin
      full    <= 1'b1;
      phase   <= 1'b0;
      char_hi <= 1'b0;
      dot_cnt <= '0;
    end else if (last_tick) begin
      full    <= 1'b0;
      phase   <= 1'b0;
      char_hi <= 1'b0;
      dot_cnt <= '0;
    end else begin
      if (full && half) phase <= !phase;
      if (tick) begin
        if (last_dot) begin
          dot_cnt <= '0;
          char_hi <= 1'b1;
        end else begin
          dot_cnt <= dot_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/planar_serializer.sv
module planar_serializer
  import planar_serializer_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [MODE_W-1:0]             clk_mode,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [PLANES*2*BYTE_W-1:0]    in_planes,
  output logic                          pix_valid,
  output logic [PLANES-1:0]             pix_index,
  output logic [1:0]                    pix_mono
);
  localparam int WORD_W = 2 * BYTE_W;

  logic              accept;
  logic              shift;
  logic              pad;
  logic              holding;
  logic [PLANES-1:0] tops;
  mono_kind_t        mono;

  dot_timer #(.BYTE_W(BYTE_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .dot8      (clk_mode[MODE_BIT_DOT8]),
    .chain     (clk_mode[MODE_BIT_CHAIN]),
    .half      (clk_mode[MODE_BIT_HALF]),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .shift     (shift),
    .pad       (pad),
    .holding   (holding),
    .pix_valid (pix_valid)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [WORD_W-1:0] lane;
    logic [WORD_W-1:0] load_word;
    assign lane      = in_planes[p*WORD_W +: WORD_W];
    assign load_word = clk_mode[MODE_BIT_CHAIN] ? lane
                                                : {lane[BYTE_W-1:0], {BYTE_W{1'b0}}};
    plane_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .load      (accept),
      .shift     (shift),
      .load_word (load_word),
      .top_bit   (tops[p])
    );
  end

  assign pix_index = (holding && !pad) ? tops : '0;
  assign mono      = mono_kind_t'({pix_index[2], pix_index[0]});
  assign pix_mono  = mono;
endmodule

// File: rtl/planar_serializer_chk.sv
module planar_serializer_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  clk_mode,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_planes,
  input logic        pix_valid,
  input logic [3:0]  pix_index
);
  function automatic logic [3:0] first_index(input logic [63:0] d, input logic chain);
    logic [3:0] r;
    for (int p = 0; p < 4; p++) r[p] = chain ? d[p*16+15] : d[p*16+7];
    return r;
  endfunction

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !pix_valid));

  assert_accept_shows_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> pix_valid);

  assert_first_pixel_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      (pix_index == first_index($past(in_planes), $past(clk_mode[2]))));

  assert_half_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (clk_mode[3] && pix_valid) |=> (!pix_valid && $stable(pix_index)));

  assert_full_rate_R4: assert property (@(posedge clk) disable iff (rst)
    (!clk_mode[3] && pix_valid && !in_ready) |=> pix_valid);
endmodule

bind planar_serializer planar_serializer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_mode  (clk_mode),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_planes (in_planes),
  .pix_valid (pix_valid),
  .pix_index (pix_index)
);

// File: tb/planar_serializer_test.sv
module planar_serializer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  clk_mode = 4'b0001;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_planes = '0;
  logic        pix_valid;
  logic [3:0]  pix_index;
  logic [1:0]  pix_mono;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit       q_val[$];
  bit [3:0] q_idx[$];

  always #2 clk = !clk;

  planar_serializer uut (
    .clk(clk), .rst(rst), .clk_mode(clk_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_planes(in_planes), .pix_valid(pix_valid),
    .pix_index(pix_index), .pix_mono(pix_mono)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: pixels of one transfer in display order.
  task automatic push_load(input logic [63:0] d);
    int nchar = clk_mode[2] ? 2 : 1;
    for (int c = 0; c < nchar; c++) begin
      for (int b = 7; b >= 0; b--) begin
        bit [3:0] ix;
        for (int p = 0; p < 4; p++)
          ix[p] = (clk_mode[2] && c == 0) ? d[p*16 + 8 + b] : d[p*16 + b];
        q_val.push_back(1'b1); q_idx.push_back(ix);
        if (clk_mode[3]) begin q_val.push_back(1'b0); q_idx.push_back(ix); end
      end
      if (!clk_mode[0]) begin
        q_val.push_back(1'b1); q_idx.push_back(4'd0);
        if (clk_mode[3]) begin q_val.push_back(1'b0); q_idx.push_back(4'd0); end
      end
    end
  endtask

  task automatic cycle(input bit v, input logic [63:0] d, output bit acc);
    bit ev;
    bit [3:0] ei;
    bit er;
    @(negedge clk);
    er = (q_val.size() <= 1);
    if (q_val.size() > 0) begin ev = q_val[0]; ei = q_idx[0]; end
    else begin ev = 1'b0; ei = 4'd0; end
    check(pix_valid == ev, "R4 R7 pix_valid", int'(pix_valid), int'(ev));
    check(pix_index == ei, "R1 R2 R3 R5 pix_index", int'(pix_index), int'(ei));
    check(in_ready == er, "R6 in_ready", int'(in_ready), int'(er));
    check(pix_mono == {ei[2], ei[0]}, "R8 pix_mono", int'(pix_mono), int'({ei[2], ei[0]}));
    if (q_val.size() > 0) begin void'(q_val.pop_front()); void'(q_idx.pop_front()); end
    in_valid  = v;
    in_planes = d;
    acc = v && (q_val.size() == 0);
    if (acc) push_load(d);
  endtask

  task automatic send(input logic [63:0] d);
    bit acc = 0;
    while (!acc) cycle(1'b1, d, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cycle(1'b0, '0, acc);
  endtask

  task automatic drain();
    bit acc;
    while (q_val.size() > 0) cycle(1'b0, '0, acc);
    cycle(1'b0, '0, acc);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
    check(pix_valid == 1'b0, "R9 reset pix_valid", int'(pix_valid), 0);
    rst = 1'b0;
    idle(2);
    for (int m = 0; m < 8; m++) begin
      drain();
      clk_mode = {m[2], m[1], 1'b0, m[0]};
      for (int k = 0; k < 4; k++) send({$urandom, $urandom});
      idle(3);
      send(64'h8001_4002_2004_1008);
      send(64'hFFFF_0000_A5A5_5A5A);
      idle(1);
      send(64'h00FF_FF00_0F0F_F0F0);
      drain();
    end
    // R9: reset while holding data discards it
    clk_mode = 4'b0101;
    send(64'h1234_5678_9ABC_DEF0);
    idle(3);
    rst = 1'b1;
    q_val.delete(); q_idx.delete();
    idle(2);
    rst = 1'b0;
    idle(3);
    send(64'hF0F0_0F0F_FF00_00FF);
    drain();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule